// File: doc/BRIEF.md
# HI/LO Multiply-Divide Accumulate Unit

This unit holds the two 32-bit result registers of a MIPS-style integer core, called HI and LO, and treats them as one 64-bit pair with HI as the upper half. It provides signed and unsigned 32x32 multiplication into the pair, plus multiply-add and multiply-subtract that update the pair in place. It also provides signed and unsigned division, and direct loads of either register. Multiplies and loads take effect on the clock edge that accepts them. Division runs on an iterative restoring divider that works for 32 cycles.

Commands arrive on a valid/ready channel. A command moves when `cmd_valid` and `cmd_ready` are both high at a rising edge. `cmd_ready` is low while the divider works. A producer facing back-pressure keeps `cmd_valid`, `cmd_op` and both operands steady until the command is taken. Results come out through a read port that has no handshake on the request side. `rd_ready` is high when `rd_data` is a settled value of the register picked by `rd_sel`. While a divide is running, `rd_ready` is low, and a consumer must wait for it before taking the value.

Opcodes on `cmd_op`: 0 signed multiply, 1 unsigned multiply, 2 signed multiply-add, 3 unsigned multiply-add, 4 signed multiply-subtract, 5 unsigned multiply-subtract, 6 signed divide, 7 unsigned divide, 8 load HI, 9 load LO. Codes 10 to 15 are spare.

Top module: `hilo_muldiv`

## Requirements
- R1: Opcodes 0 (signed, both operands sign-extended) and 1 (unsigned, both operands zero-extended) form `cmd_a*cmd_b` as a 64-bit product. The low 32 bits go to LO and the high 32 bits go to HI, at the accepting edge.
- R2: Opcodes 2/3 set HI:LO to HI:LO plus the product, and opcodes 4/5 set HI:LO to HI:LO minus the product, modulo 2^64. Even opcodes are signed and odd opcodes are unsigned. The update happens at the accepting edge.
- R3: Opcodes 6 (signed) and 7 (unsigned) with a nonzero divisor put the quotient of `cmd_a/cmd_b` in LO and the remainder in HI. The signed quotient truncates toward zero, and the remainder takes the dividend's sign.
- R4: A divide with `cmd_b` equal to zero writes 0 to both HI and LO at the accepting edge, and `busy` stays low.
- R5: A divide with a nonzero divisor holds `busy` high for exactly 32 cycles after the accepting edge. HI and LO keep their values during that time and take the result at the edge where `busy` falls.
- R6: While `busy` is high, `cmd_ready` is low and no command is taken. A held command is taken at the first edge after `busy` falls.
- R7: `rd_ready` equals not `busy`. When it is high, `rd_data` shows HI if `rd_sel` is 1 and LO if `rd_sel` is 0.
- R8: Opcode 8 loads HI from `cmd_a`, and opcode 9 loads LO from `cmd_a`. The other register is unchanged.
- R9: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R10: After reset, HI and LO are 0, and `busy` is low.
- R11: Opcodes 10 to 15 are taken and change neither HI nor LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 4 | Operation code |
| cmd_a | input | 32 | First operand / dividend / load value |
| cmd_b | input | 32 | Second operand / divisor |
| busy | output | 1 | Divider working |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_ready | output | 1 | `rd_data` is settled |
| rd_data | output | 32 | Selected register value |

## Verification
A corrupted pair shows on `rd_data` in the first cycle after the bad edge, because the read port is combinational from the registers. A divider step-count fault shows as a `busy` pulse of the wrong length, which changes when `cmd_ready` rises and when the result appears, so it is seen within 33 cycles of the accepting edge. A wrong sign fix-up or restore decision shows only in the final quotient and remainder, so the stimulus mixes operand signs and includes divisors larger than the dividend.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  localparam logic [3:0] OP_MULS  = 4'd0;
  localparam logic [3:0] OP_MULU  = 4'd1;
  localparam logic [3:0] OP_MACS  = 4'd2;
  localparam logic [3:0] OP_MACU  = 4'd3;
  localparam logic [3:0] OP_MSBS  = 4'd4;
  localparam logic [3:0] OP_MSBU  = 4'd5;
  localparam logic [3:0] OP_DIVS  = 4'd6;
  localparam logic [3:0] OP_DIVU  = 4'd7;
  localparam logic [3:0] OP_SETHI = 4'd8;
  localparam logic [3:0] OP_SETLO = 4'd9;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_SUB  = 2'd2
  } acc_mode_e;
endpackage

// File: rtl/hilo_mult.sv
module hilo_mult
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  input  acc_mode_e      mode,
  input  logic [2*W-1:0] acc,
  output logic [2*W-1:0] res
);
  localparam int XW = 2 * W;

  logic signed [W:0]    ax, bx;
  logic signed [XW+1:0] full;
  logic [XW-1:0]        prod;

  always_comb begin
    ax   = {sgn & a[W-1], a};
    bx   = {sgn & b[W-1], b};
    full = ax * bx;
    prod = full[XW-1:0];
    unique case (mode)
      ACC_ADD: res = acc + prod;
      ACC_SUB: res = acc - prod;
      default: res = prod;
    endcase
  end
endmodule

// File: rtl/hilo_divider.sv
module hilo_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dsr,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  q_q, r_q, d_q;
  logic          nq_q, nr_q;

  logic          a_neg, b_neg;
  logic [W-1:0]  a_mag, b_mag;
  logic [W:0]    shifted, diff;
  logic          take;
  logic [W-1:0]  r_next, q_next;

  always_comb begin
    a_neg   = sgn & dvd[W-1];
    b_neg   = sgn & dsr[W-1];
    a_mag   = a_neg ? (~dvd + 1'b1) : dvd;
    b_mag   = b_neg ? (~dsr + 1'b1) : dsr;
    shifted = {r_q, q_q[W-1]};
    diff    = shifted - {1'b0, d_q};
    take    = ~diff[W];
    r_next  = take ? diff[W-1:0] : shifted[W-1:0];
    q_next  = {q_q[W-2:0], take};
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == LAST);
  assign quo  = nq_q ? (~q_next + 1'b1) : q_next;
  assign rem  = nr_q ? (~r_next + 1'b1) : r_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      nq_q   <= 1'b0;
      nr_q   <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      q_q    <= a_mag;
      r_q    <= '0;
      d_q    <= b_mag;
      nq_q   <= a_neg ^ b_neg;
      nr_q   <= a_neg;
    end else if (busy_q) begin
      q_q   <= q_next;
      r_q   <= r_next;
      cnt_q <= cnt_q + 1'b1;
      if (done) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [3:0]   cmd_op,
  input  logic [W-1:0] cmd_a,
  input  logic [W-1:0] cmd_b,
  output logic         busy,
  input  logic         rd_sel,
  output logic         rd_ready,
  output logic [W-1:0] rd_data
);
  logic [W-1:0]   hi_q, lo_q;
  logic           accept, is_mul, is_div, dz, div_start;
  acc_mode_e      mode;
  logic [2*W-1:0] mres;
  logic           dv_busy, dv_done;
  logic [W-1:0]   dv_quo, dv_rem;

  always_comb begin
    accept    = cmd_valid && cmd_ready;
    is_mul    = (cmd_op <= OP_MSBU);
    is_div    = (cmd_op == OP_DIVS) || (cmd_op == OP_DIVU);
    dz        = (cmd_b == '0);
    div_start = accept && is_div && !dz;
    unique case (cmd_op[2:1])
      2'd1:    mode = ACC_ADD;
      2'd2:    mode = ACC_SUB;
      default: mode = ACC_NONE;
    endcase
  end

  hilo_mult #(.W(W)) u_mult (
    .a    (cmd_a),
    .b    (cmd_b),
    .sgn  (~cmd_op[0]),
    .mode (mode),
    .acc  ({hi_q, lo_q}),
    .res  (mres)
  );

  hilo_divider #(.W(W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .sgn   (~cmd_op[0]),
    .dvd   (cmd_a),
    .dsr   (cmd_b),
    .busy  (dv_busy),
    .done  (dv_done),
    .quo   (dv_quo),
    .rem   (dv_rem)
  );

  assign busy      = dv_busy;
  assign cmd_ready = ~dv_busy;
  assign rd_ready  = ~dv_busy;
  assign rd_data   = rd_sel ? hi_q : lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (dv_done) begin
      hi_q <= dv_rem;
      lo_q <= dv_quo;
    end else if (accept) begin
      if (is_mul) begin
        {hi_q, lo_q} <= mres;
      end else if (is_div && dz) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (cmd_op == OP_SETHI) begin
        hi_q <= cmd_a;
      end else if (cmd_op == OP_SETLO) begin
        lo_q <= cmd_a;
      end
    end
  end
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic [3:0]   cmd_op,
  input logic [W-1:0] cmd_a,
  input logic [W-1:0] cmd_b,
  input logic         busy,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int RW = $clog2(W) + 1;
  logic [RW-1:0] run_q;
  logic          acc;

  assign acc = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_q < RW'(W));

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(run_q) == RW'(W - 1));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(hi_q) && $stable(lo_q));

  // R4
  divzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == 4'd6 || cmd_op == 4'd7) && cmd_b == '0
      |=> hi_q == '0 && lo_q == '0 && !busy);

  // R8
  sethi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd8 |=> hi_q == $past(cmd_a) && lo_q == $past(lo_q));

  // R1
  mulu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd1
      |=> {hi_q, lo_q} == {{W{1'b0}}, $past(cmd_a)} * {{W{1'b0}}, $past(cmd_b)});
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W)) u_chk (.*);

// File: tb/hilo_muldiv_bench.sv
module hilo_muldiv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic        busy;
  logic        rd_sel = 1'b0;
  logic        rd_ready;
  logic [31:0] rd_data;

  int nvec = 0, nfail = 0;

  always #10 clk = ~clk;

  hilo_muldiv u_hilo_muldiv (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy),
    .rd_sel(rd_sel), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  // behavioural reference
  logic [31:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
  int          m_cnt = 0;
  logic        m_took = 1'b0;

  always @(posedge clk) begin
    logic [63:0] pair, prod;
    longint sa, sb;
    if (!rst_n) begin
      m_hi <= '0; m_lo <= '0; m_cnt <= 0; m_took <= 1'b0;
    end else begin
      m_took <= 1'b0;
      if (m_cnt != 0) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin m_hi <= p_hi; m_lo <= p_lo; end
      end else if (cmd_valid) begin
        m_took <= 1'b1;
        pair = {m_hi, m_lo};
        sa = longint'($signed(cmd_a));
        sb = longint'($signed(cmd_b));
        if (cmd_op[0]) prod = {32'd0, cmd_a} * {32'd0, cmd_b};
        else           prod = 64'(sa * sb);
        case (cmd_op)
          4'd0, 4'd1: {m_hi, m_lo} <= prod;
          4'd2, 4'd3: {m_hi, m_lo} <= pair + prod;
          4'd4, 4'd5: {m_hi, m_lo} <= pair - prod;
          4'd6, 4'd7: begin
            if (cmd_b == 0) begin
              m_hi <= '0; m_lo <= '0;
            end else begin
              m_cnt <= 32;
              if (cmd_op == 4'd6) begin
                p_lo <= 32'(sa / sb); p_hi <= 32'(sa % sb);
              end else begin
                p_lo <= cmd_a / cmd_b; p_hi <= cmd_a % cmd_b;
              end
            end
          end
          4'd8: m_hi <= cmd_a;
          4'd9: m_lo <= cmd_a;
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison (R5 R6 R7 and all register results)
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      nvec++;
      if (busy !== (m_cnt != 0) || cmd_ready !== (m_cnt == 0) || rd_ready !== (m_cnt == 0)) begin
        nfail++;
        $display("FAIL R5 R6 R7 handshake: busy=%0b ready=%0b/%0b expected busy=%0b",
                 busy, cmd_ready, rd_ready, m_cnt != 0);
      end else if (m_cnt == 0 && rd_data !== (rd_sel ? m_hi : m_lo)) begin
        nfail++;
        $display("FAIL R1 R2 R3 R8 R11 register sel=%0b: got %h expected %h",
                 rd_sel, rd_data, rd_sel ? m_hi : m_lo);
      end
    end
  end

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    do @(negedge clk); while (!m_took);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_cnt != 0) @(negedge clk);
  endtask

  task automatic check_pair(input logic [31:0] ehi, input logic [31:0] elo, input string req);
    wait_idle();
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      rd_sel = s[0];
      #1;
      nvec++;
      if (rd_data !== (s[0] ? ehi : elo)) begin
        nfail++;
        $display("FAIL %s %s: got %h expected %h", req, s[0] ? "HI" : "LO",
                 rd_data, s[0] ? ehi : elo);
      end
    end
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h8000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'($urandom_range(0, 20));
      3: return 32'd0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    nvec++;
    if (busy !== 1'b0) begin nfail++; $display("FAIL R10 busy: got %0b expected 0", busy); end
    check_pair(32'h0, 32'h0, "R10");

    issue(4'd0, 32'hFFFF_FFFD, 32'd7);               // R1 signed -3*7
    check_pair(32'hFFFF_FFFF, 32'hFFFF_FFEB, "R1");
    issue(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);       // R1 unsigned
    check_pair(32'hFFFF_FFFE, 32'h0000_0001, "R1");

    issue(4'd8, 32'd0, 32'd0);                       // R8
    issue(4'd9, 32'd100, 32'd0);
    check_pair(32'h0, 32'd100, "R8");
    issue(4'd2, 32'd3, 32'd4);                       // R2 madd
    check_pair(32'h0, 32'd112, "R2");
    issue(4'd4, 32'd10, 32'd20);                     // R2 msub -> -88
    check_pair(32'hFFFF_FFFF, 32'hFFFF_FFA8, "R2");
    issue(4'd3, 32'hFFFF_FFFF, 32'd2);               // R2 unsigned madd
    check_pair(32'h0000_0001, 32'hFFFF_FFA6, "R2");
    issue(4'd5, 32'h0000_0001, 32'h0000_0002);       // R2 unsigned msub
    check_pair(32'h0000_0001, 32'hFFFF_FFA4, "R2");

    issue(4'd6, 32'hFFFF_FFF9, 32'd2);               // R3 -7/2
    check_pair(32'hFFFF_FFFF, 32'hFFFF_FFFD, "R3");
    issue(4'd6, 32'd7, 32'hFFFF_FFFE);               // R3 7/-2
    check_pair(32'h0000_0001, 32'hFFFF_FFFD, "R3");
    issue(4'd7, 32'd100, 32'd7);                     // R3 unsigned
    check_pair(32'd2, 32'd14, "R3");
    issue(4'd7, 32'd5, 32'hFFFF_FFF0);               // R3 divisor > dividend
    check_pair(32'd5, 32'd0, "R3");
    issue(4'd6, 32'h8000_0000, 32'hFFFF_FFFF);       // R9
    check_pair(32'h0, 32'h8000_0000, "R9");
    issue(4'd6, 32'd5, 32'd0);                       // R4
    nvec++;
    if (busy !== 1'b0) begin nfail++; $display("FAIL R4 busy: got %0b expected 0", busy); end
    check_pair(32'h0, 32'h0, "R4");

    // R5 busy length, R6 held command
    issue(4'd7, 32'd1000, 32'd9);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    nvec++;
    if (n != 32) begin nfail++; $display("FAIL R5 busy cycles: got %0d expected 32", n); end
    issue(4'd7, 32'd50, 32'd8);
    issue(4'd9, 32'h55, 32'd0);                      // held off for 32 cycles
    check_pair(32'd2, 32'h55, "R6");

    issue(4'd12, 32'hDEAD_BEEF, 32'd3);              // R11 spare opcode
    check_pair(32'd2, 32'h55, "R11");

    for (int i = 0; i < 400; i++) begin
      issue(4'($urandom_range(0, 15)), pick(), pick());
      @(negedge clk) rd_sel = $urandom_range(0, 1);
    end
    wait_idle();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule